// File: doc/BRIEF.md
# Reflected CRC-32 Two-Cycle Step Unit

This block advances a reflected (LSB-first) 32-bit CRC register by 8, 16 or 32 data bits in one operation. The caller places the register value, with the data bits to be consumed already XORed into its low end, on the input. It then pulses a start strobe and picks a generator and a step size. Two generators are available: the CRC-32 polynomial used by HDLC, Ethernet and zlib, and the Castagnoli polynomial CRC-32C. Two cycles later the block returns the updated register with a one-cycle done strobe.

The step does not walk the bits one by one and does not use a table. In the first cycle a carry-less product of the outgoing bits with the Barrett constant of the selected generator gives the polynomial quotient. In the second cycle a carry-less product of that quotient with the generator gives the remainder. That remainder is folded into the surviving high bits of the register. The Barrett constants are derived from the generator parameters at elaboration.

A new operation can start every second cycle. Message buffering and the initial and final inversions of a CRC stay with the caller.

Top module: `crc32_step_unit`

## Requirements
- R1: While reset is asserted and after it is released, until the first result, `done_o` is 0 and `result_o` is 0.
- R2: A start that is accepted at a clock edge produces `done_o` high after the second clock edge that follows, and `result_o` holds the new value in that same cycle.
- R3: `done_o` is high for exactly one cycle per accepted start.
- R4: A start presented in the cycle right after an accepted start is ignored: no extra done pulse and no change to the pending result. A start two cycles after acceptance is accepted.
- R5: `result_o` keeps its last value in every cycle in which `done_o` is low.
- R6: With `poly_sel_i` = 0 the result equals n iterations of x = (x >> 1) ^ (x[0] ? 0xEDB88320 : 0) applied to `value_i`.
- R7: With `poly_sel_i` = 1 the same rule holds with the constant 0x82F63B78.
- R8: `size_sel_i` sets n: 0 gives 8, 1 gives 16, 2 gives 32, and 3 also gives 32.
- R9: An all-zero input gives an all-zero result for every generator and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| poly_sel_i | input | 1 | Generator: 0 CRC-32, 1 CRC-32C |
| size_sel_i | input | 2 | Bits consumed: 0→8, 1→16, 2/3→32 |
| value_i | input | 32 | Reflected CRC register with data mixed in |
| result_o | output | 32 | Updated reflected CRC register |
| done_o | output | 1 | One-cycle result-valid strobe |

## Verification
A wrong quotient in the first stage, or a wrong generator constant, changes `result_o` at the done pulse of that operation. A comparison against a bit-serial model therefore exposes it two cycles after the start. A wrong busy flag shows up as a done pulse with no expected item behind it, or as a missing one. A wrong latency shows up as a done pulse in a cycle other than the second after acceptance. Zero inputs and every size are mixed with random values, so that shift-alignment faults and constant faults each show up at the very next result.

// File: rtl/crc_step_pkg.sv
package crc_step_pkg;

  localparam int unsigned CRC_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } crc_size_e;

  function automatic logic [CRC_W-1:0] bit_rev32(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  function automatic logic [2*CRC_W-1:0] clmul32(input logic [CRC_W-1:0] a,
                                                 input logic [CRC_W-1:0] b);
    logic [2*CRC_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < CRC_W; i++)
      if (b[i]) acc = acc ^ ({{CRC_W{1'b0}}, a} << i);
    return acc;
  endfunction

  // floor(x^64 / {1,p}) with the leading x^32 term dropped
  function automatic logic [CRC_W-1:0] barrett_mu(input logic [CRC_W-1:0] p);
    logic [CRC_W:0]   r;
    logic [CRC_W-1:0] q;
    r = '0;
    q = '0;
    for (int i = 2*CRC_W; i >= 0; i--) begin
      r = {r[CRC_W-1:0], (i == 2*CRC_W)};
      if (r[CRC_W]) begin
        if (i < CRC_W) q[i] = 1'b1;
        r = r ^ {1'b1, p};
      end
    end
    return q;
  endfunction

endpackage

// File: rtl/crc_step_consts.sv
module crc_step_consts
  import crc_step_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY0_REFL = 32'hEDB88320,
  parameter logic [CRC_W-1:0] POLY1_REFL = 32'h82F63B78
) (
  input  logic             sel_i,
  output logic [CRC_W-1:0] poly_o,
  output logic [CRC_W-1:0] mu_o
);

  localparam int unsigned NPOLY = 2;
  localparam logic [NPOLY*CRC_W-1:0] REFL_TAB = {POLY1_REFL, POLY0_REFL};

  logic [CRC_W-1:0] poly_tab [NPOLY];
  logic [CRC_W-1:0] mu_tab   [NPOLY];

  for (genvar g = 0; g < NPOLY; g++) begin : g_poly
    localparam logic [CRC_W-1:0] PNORM = bit_rev32(REFL_TAB[g*CRC_W +: CRC_W]);
    localparam logic [CRC_W-1:0] MU    = barrett_mu(PNORM);
    assign poly_tab[g] = PNORM;
    assign mu_tab[g]   = MU;
  end

  assign poly_o = poly_tab[sel_i];
  assign mu_o   = mu_tab[sel_i];

endmodule

// File: rtl/crc_step_front.sv
module crc_step_front
  import crc_step_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY0_REFL = 32'hEDB88320,
  parameter logic [CRC_W-1:0] POLY1_REFL = 32'h82F63B78
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             poly_i,
  input  logic [1:0]       size_i,
  input  logic [CRC_W-1:0] value_i,
  output logic             vld_o,
  output logic             poly_o,
  output logic [CRC_W-1:0] quot_o,
  output logic [CRC_W-1:0] tail_o
);

  logic             vld_q, vld_d;
  logic             poly_q;
  logic [CRC_W-1:0] quot_q, quot_d;
  logic [CRC_W-1:0] tail_q, tail_d;
  logic             accept;
  logic [CRC_W-1:0] mu;
  logic [CRC_W-1:0] unused_poly;
  logic [CRC_W-1:0] rev_val;
  logic [CRC_W-1:0] head;
  logic [2*CRC_W-1:0] prod;

  crc_step_consts #(.POLY0_REFL(POLY0_REFL), .POLY1_REFL(POLY1_REFL)) u_consts (
    .sel_i  (poly_i),
    .poly_o (unused_poly),
    .mu_o   (mu)
  );

  assign accept = start_i & ~vld_q;

  always_comb begin
    rev_val = bit_rev32(value_i);
    case (crc_size_e'(size_i))
      SZ_BYTE: begin head = rev_val >> 24; tail_d = value_i >> 8;  end
      SZ_HALF: begin head = rev_val >> 16; tail_d = value_i >> 16; end
      default: begin head = rev_val;       tail_d = '0;            end
    endcase
    prod   = clmul32(head, mu);
    quot_d = head ^ prod[2*CRC_W-1:CRC_W];
    vld_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= 1'b0;
      quot_q <= '0;
      tail_q <= '0;
    end else if (accept) begin
      poly_q <= poly_i;
      quot_q <= quot_d;
      tail_q <= tail_d;
    end
  end

  assign vld_o  = vld_q;
  assign poly_o = poly_q;
  assign quot_o = quot_q;
  assign tail_o = tail_q;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R4
  AST_ACCEPT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !vld_q) |=> vld_q); // R2

endmodule

// File: rtl/crc_step_back.sv
module crc_step_back
  import crc_step_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY0_REFL = 32'hEDB88320,
  parameter logic [CRC_W-1:0] POLY1_REFL = 32'h82F63B78
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             poly_i,
  input  logic [CRC_W-1:0] quot_i,
  input  logic [CRC_W-1:0] tail_i,
  output logic [CRC_W-1:0] result_o,
  output logic             done_o
);

  logic [CRC_W-1:0]   pnorm;
  logic [CRC_W-1:0]   unused_mu;
  logic [2*CRC_W-1:0] prod;
  logic [CRC_W-1:0]   res_d, res_q;
  logic               done_d, done_q;

  crc_step_consts #(.POLY0_REFL(POLY0_REFL), .POLY1_REFL(POLY1_REFL)) u_consts (
    .sel_i  (poly_i),
    .poly_o (pnorm),
    .mu_o   (unused_mu)
  );

  always_comb begin
    prod   = clmul32(quot_i, pnorm);
    res_d  = tail_i ^ bit_rev32(prod[CRC_W-1:0]);
    done_d = vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res_q <= '0;
    else if (vld_i) res_q <= res_d;
  end

  assign result_o = res_q;
  assign done_o   = done_q;

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> done_q); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(res_q)); // R5
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && quot_i == '0 && tail_i == '0) |=> (res_q == '0)); // R9

endmodule

// File: rtl/crc32_step_unit.sv
module crc32_step_unit
  import crc_step_pkg::*;
#(
  parameter logic [31:0] POLY0_REFL = 32'hEDB88320,
  parameter logic [31:0] POLY1_REFL = 32'h82F63B78
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        poly_sel_i,
  input  logic [1:0]  size_sel_i,
  input  logic [31:0] value_i,
  output logic [31:0] result_o,
  output logic        done_o
);

  logic             s1_vld;
  logic             s1_poly;
  logic [CRC_W-1:0] s1_quot;
  logic [CRC_W-1:0] s1_tail;

  crc_step_front #(.POLY0_REFL(POLY0_REFL), .POLY1_REFL(POLY1_REFL)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .poly_i  (poly_sel_i),
    .size_i  (size_sel_i),
    .value_i (value_i),
    .vld_o   (s1_vld),
    .poly_o  (s1_poly),
    .quot_o  (s1_quot),
    .tail_o  (s1_tail)
  );

  crc_step_back #(.POLY0_REFL(POLY0_REFL), .POLY1_REFL(POLY1_REFL)) u_back (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (s1_vld),
    .poly_i   (s1_poly),
    .quot_i   (s1_quot),
    .tail_i   (s1_tail),
    .result_o (result_o),
    .done_o   (done_o)
  );

  AST_ONE_DONE_PER_START: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !s1_vld); // R3

endmodule

// File: tb/sim_crc32_step_unit.sv
`timescale 1ns/1ps
module sim_crc32_step_unit;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        poly_sel_i;
  logic [1:0]  size_sel_i;
  logic [31:0] value_i;
  logic [31:0] result_o;
  logic        done_o;

  int checks;
  int errors;
  int cyc;
  bit finished;

  typedef struct {
    logic [31:0] val;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] last_res;

  crc32_step_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poly_sel_i(poly_sel_i),
    .size_sel_i(size_sel_i), .value_i(value_i), .result_o(result_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] ref_crc(input logic [31:0] x, input bit psel,
                                          input logic [1:0] sz);
    logic [31:0] poly;
    int n;
    poly = psel ? 32'h82F63B78 : 32'hEDB88320;
    n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    for (int i = 0; i < n; i++) x = (x >> 1) ^ (x[0] ? poly : 32'h0);
    return x;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: issue one op and push its expectation
  task automatic issue(input logic [31:0] v, input bit psel, input logic [1:0] sz,
                       input string tag);
    exp_t e;
    @(negedge clk);
    start_i = 1'b1; poly_sel_i = psel; size_sel_i = sz; value_i = v;
    e.val = ref_crc(v, psel, sz);
    e.due = cyc + 2;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 unexpected done", result_o, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result_o === e.val, e.tag, result_o, e.val);
        check(cyc == e.due, "R2 latency", 32'(cyc), 32'(e.due));
      end
      last_res = result_o;
    end
  end

  initial begin
    cyc = 0; checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start_i = 1'b0; poly_sel_i = 1'b0; size_sel_i = 2'd0; value_i = '0;
    #1;
    check(done_o === 1'b0 && result_o === 32'h0, "R1 in reset", result_o, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o === 1'b0 && result_o === 32'h0, "R1 after reset", result_o, 32'h0);

    // R9 zero for every variant
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++) issue(32'h0, p[0], s[1:0], "R9 zero");

    // R6/R7/R8 fixed patterns
    issue(32'hFFFFFFFF, 1'b0, 2'd2, "R6 ones word");
    issue(32'h000000FF, 1'b0, 2'd0, "R6 byte");
    issue(32'h12345678, 1'b0, 2'd1, "R8 half");
    issue(32'h80000001, 1'b1, 2'd2, "R7 word");
    issue(32'hDEADBEEF, 1'b1, 2'd0, "R7 byte");
    issue(32'hCAFEF00D, 1'b1, 2'd3, "R8 size3 as word");
    issue(32'h00000001, 1'b0, 2'd3, "R8 size3 as word");

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [31:0] v;
      v = $urandom();
      issue(v, k[0], k[2:1], k[0] ? "R7 random" : "R6 random");
    end

    // R4: start in the busy cycle is ignored
    @(negedge clk);
    begin
      exp_t e;
      start_i = 1'b1; poly_sel_i = 1'b0; size_sel_i = 2'd2; value_i = 32'hA5A5A5A5;
      e.val = ref_crc(32'hA5A5A5A5, 1'b0, 2'd2); e.due = cyc + 2; e.tag = "R4 first kept";
      sb.push_back(e);
      @(negedge clk);
      poly_sel_i = 1'b1; size_sel_i = 2'd0; value_i = 32'h5A5A5A5A;
      @(negedge clk);
      start_i = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R4 queue drained", 32'(sb.size()), 32'h0);

    // R5: result held while done low
    check(done_o === 1'b0 && result_o === last_res, "R5 hold", result_o, last_res);
    repeat (3) @(negedge clk);
    check(result_o === last_res, "R5 hold later", result_o, last_res);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule